// File: doc/BRIEF.md
# Integer Logical Execution Unit

This unit executes the integer logical group of a 64-bit load/store RISC core. Each issued operation carries either a 10-bit extended opcode with a record flag and two source operands, or an immediate-form selector with a 16-bit unsigned constant. The unit returns a destination value and, for recording operations, a 4-bit condition field. The register-form operations are bitwise logic and its complement variants, byte and halfword sign extension, a 32-bit leading-zero count, and a byte-wise equality mask. Both the result and the condition field leave the unit through registers, one cycle after the operation is issued.

The condition field describes the sign of the 64-bit result and carries a copy of the summary-overflow bit that the caller supplies. An operation the decoder does not recognise raises a flag and leaves the previous result and condition field on the outputs. A parameter can remove the byte-compare hardware. When it is removed, that opcode decodes as undefined.

Top module: `int_logic_unit`

## Requirements
- R1: Register form (`imm_form`=0) computes `res` from `rs`,`rb` by extended opcode: 28 AND, 316 XOR, 476 NAND, 444 OR, 124 NOR, 60 rs&~rb, 284 ~(rs^rb), 412 rs|~rb.
- R2: Opcode 954 gives `rs[7:0]` sign-extended to 64 bits; opcode 922 gives `rs[15:0]` sign-extended.
- R3: Opcode 26 gives the number of leading zeros of `rs[31:0]` (bits above 31 ignored), and 32 when those bits are all zero.
- R4: Opcode 508 sets each result byte i to 0xFF when byte i of `rs` equals byte i of `rb`, else 0x00; it never updates the condition field, whatever `rec` is.
- R5: A legal register-form operation other than 508 with `rec`=1 raises `cr_we` and loads `cr_out` = {LT,GT,EQ,SO} (bit 3 down to 0), where LT/GT/EQ come from a signed compare of the 64-bit result against zero and SO is `so_in`.
- R6: With `rec`=0 a register-form operation keeps `cr_we` low and `cr_out` unchanged.
- R7: Immediate form (`imm_form`=1) zero-extends `imm` and combines it with `rs` by `imm_op`: 0 OR, 1 OR with imm shifted left 16, 2 XOR, 3 XOR shifted, 4 AND, 5 AND shifted; `xop` has no effect.
- R8: Immediate `imm_op` 4 and 5 always update the condition field as in R5, whatever `rec` is; `imm_op` 0 to 3 never do.
- R9: An undefined extended opcode, or `imm_op` 6 or 7, gives `illegal`=1 with `out_valid` one cycle later, keeps `cr_we` low, and leaves `res` and `cr_out` unchanged.
- R10: `out_valid` equals `in_valid` one cycle earlier; in a cycle after `in_valid`=0, `cr_we` and `illegal` are low and `res`/`cr_out` hold.
- R11: After reset `out_valid`, `cr_we`, `illegal`, `res` and `cr_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation issued this cycle |
| imm_form | input | 1 | 1 = immediate form, 0 = register form |
| xop | input | 10 | Extended opcode (register form) |
| imm_op | input | 3 | Immediate-form selector |
| rec | input | 1 | Record request (register form) |
| imm | input | 16 | Unsigned immediate |
| rs | input | 64 | First source operand |
| rb | input | 64 | Second source operand (register form) |
| so_in | input | 1 | Summary-overflow bit |
| out_valid | output | 1 | Result issued one cycle ago is present |
| res | output | 64 | Destination value |
| cr_out | output | 4 | Condition field {LT,GT,EQ,SO} |
| cr_we | output | 1 | Condition field was updated this cycle |
| illegal | output | 1 | Issued operation was undefined |

## Verification
The result write and the condition-field update can happen in the same cycle. So can an undefined-opcode report and the hold of both outputs. The bench drives back-to-back streams in which recording, non-recording, forced-recording immediate and undefined operations follow one another with no idle cycles, and `so_in` changes on every cycle. A behavioural model in the bench predicts every output each cycle. It judges whether an undefined or non-recording operation placed straight after a recording one leaves the previous `res` and `cr_out` untouched. It also judges whether results equal to zero or with the top bit set yield the correct single sign flag together with the SO copy.

// File: rtl/ilu_pkg.sv
package ilu_pkg;

   typedef enum logic [3:0] {
      OP_AND,
      OP_XOR,
      OP_NAND,
      OP_OR,
      OP_NOR,
      OP_ANDC,
      OP_EQV,
      OP_ORC,
      OP_EXTB,
      OP_EXTH,
      OP_CLZ,
      OP_CMPB
   } ilu_op_e;

   typedef struct packed {
      ilu_op_e op;
      logic    use_imm;
      logic    imm_hi;
      logic    rec_en;
      logic    legal;
   } ilu_ctl_t;

endpackage

// File: rtl/ilu_decode.sv
module ilu_decode
   import ilu_pkg::*;
#(
   parameter int XOP_W       = 10,
   parameter int SEL_W       = 3,
   parameter bit ENABLE_CMPB = 1'b1
) (
   input  logic             imm_form,
   input  logic [XOP_W-1:0] xop,
   input  logic [SEL_W-1:0] imm_op,
   input  logic             rec,
   output ilu_ctl_t         ctl
);

   if (XOP_W < 10) begin : g_bad_xop
      $error("ilu_decode: XOP_W must hold 10-bit opcodes");
   end
   if (SEL_W < 3) begin : g_bad_sel
      $error("ilu_decode: SEL_W must be at least 3");
   end

   always_comb begin
      ctl         = '0;
      ctl.op      = OP_AND;
      ctl.legal   = 1'b1;
      if (imm_form) begin
         ctl.use_imm = 1'b1;
         ctl.imm_hi  = imm_op[0];
         unique case (imm_op)
            SEL_W'(0), SEL_W'(1): ctl.op = OP_OR;
            SEL_W'(2), SEL_W'(3): ctl.op = OP_XOR;
            SEL_W'(4), SEL_W'(5): begin
               ctl.op     = OP_AND;
               ctl.rec_en = 1'b1;
            end
            default: ctl.legal = 1'b0;
         endcase
      end else begin
         ctl.rec_en = rec;
         unique case (xop)
            XOP_W'(28):  ctl.op = OP_AND;
            XOP_W'(316): ctl.op = OP_XOR;
            XOP_W'(476): ctl.op = OP_NAND;
            XOP_W'(444): ctl.op = OP_OR;
            XOP_W'(124): ctl.op = OP_NOR;
            XOP_W'(60):  ctl.op = OP_ANDC;
            XOP_W'(284): ctl.op = OP_EQV;
            XOP_W'(412): ctl.op = OP_ORC;
            XOP_W'(954): ctl.op = OP_EXTB;
            XOP_W'(922): ctl.op = OP_EXTH;
            XOP_W'(26):  ctl.op = OP_CLZ;
            XOP_W'(508): begin
               ctl.op     = OP_CMPB;
               ctl.rec_en = 1'b0;
               ctl.legal  = ENABLE_CMPB;
            end
            default: begin
               ctl.legal  = 1'b0;
               ctl.rec_en = 1'b0;
            end
         endcase
      end
      if (!ctl.legal) begin
         ctl.rec_en = 1'b0;
      end
   end

endmodule

// File: rtl/ilu_alu.sv
module ilu_alu
   import ilu_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int IMM_W       = 16,
   parameter bit ENABLE_CMPB = 1'b1
) (
   input  ilu_ctl_t          ctl,
   input  logic [XLEN-1:0]   rs,
   input  logic [XLEN-1:0]   rb,
   input  logic [IMM_W-1:0]  imm,
   output logic [XLEN-1:0]   res
);

   localparam int NBYTES = XLEN / 8;
   localparam int CLZ_W  = 32;
   localparam int CNT_W  = $clog2(CLZ_W + 1);

   if (XLEN % 8 != 0) begin : g_bad_xlen
      $error("ilu_alu: XLEN must be a whole number of bytes");
   end
   if (XLEN < 2 * IMM_W || XLEN < CLZ_W) begin : g_bad_imm
      $error("ilu_alu: XLEN too narrow for shifted immediate or count");
   end

   logic [XLEN-1:0]  imm_z;
   logic [XLEN-1:0]  opb;
   logic [XLEN-1:0]  bytes_eq;
   logic [CNT_W-1:0] lz;

   assign imm_z = XLEN'(imm);
   assign opb   = ctl.use_imm ? (ctl.imm_hi ? (imm_z << IMM_W) : imm_z) : rb;

   // Byte-wise equality mask, one lane per byte
   if (ENABLE_CMPB) begin : g_cmpb
      for (genvar g = 0; g < NBYTES; g++) begin : g_lane
         assign bytes_eq[g*8 +: 8] = (rs[g*8 +: 8] == rb[g*8 +: 8]) ? 8'hFF : 8'h00;
      end
   end else begin : g_no_cmpb
      assign bytes_eq = '0;
   end

   // Leading-zero count over the low word; highest set bit wins
   always_comb begin
      lz = CNT_W'(CLZ_W);
      for (int i = 0; i < CLZ_W; i++) begin
         if (rs[i]) lz = CNT_W'(CLZ_W - 1 - i);
      end
   end

   always_comb begin
      unique case (ctl.op)
         OP_AND:  res = rs & opb;
         OP_XOR:  res = rs ^ opb;
         OP_NAND: res = ~(rs & opb);
         OP_OR:   res = rs | opb;
         OP_NOR:  res = ~(rs | opb);
         OP_ANDC: res = rs & ~opb;
         OP_EQV:  res = ~(rs ^ opb);
         OP_ORC:  res = rs | ~opb;
         OP_EXTB: res = {{(XLEN-8){rs[7]}}, rs[7:0]};
         OP_EXTH: res = {{(XLEN-16){rs[15]}}, rs[15:0]};
         OP_CLZ:  res = XLEN'(lz);
         OP_CMPB: res = bytes_eq;
         default: res = '0;
      endcase
   end

endmodule

// File: rtl/ilu_cond.sv
module ilu_cond #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0] val,
   input  logic            so,
   output logic [3:0]      cr
);

   logic neg, zero;

   assign neg  = val[XLEN-1];
   assign zero = (val == '0);
   assign cr   = {neg, !neg && !zero, zero, so};

endmodule

// File: rtl/int_logic_unit.sv
module int_logic_unit
   import ilu_pkg::*;
#(
   parameter int XLEN        = 64,
   parameter int IMM_W       = 16,
   parameter int XOP_W       = 10,
   parameter int SEL_W       = 3,
   parameter bit ENABLE_CMPB = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             imm_form,
   input  logic [XOP_W-1:0] xop,
   input  logic [SEL_W-1:0] imm_op,
   input  logic             rec,
   input  logic [IMM_W-1:0] imm,
   input  logic [XLEN-1:0]  rs,
   input  logic [XLEN-1:0]  rb,
   input  logic             so_in,
   output logic             out_valid,
   output logic [XLEN-1:0]  res,
   output logic [3:0]       cr_out,
   output logic             cr_we,
   output logic             illegal
);

   ilu_ctl_t        ctl;
   logic [XLEN-1:0] alu_res;
   logic [3:0]      cr_next;

   ilu_decode #(.XOP_W(XOP_W), .SEL_W(SEL_W), .ENABLE_CMPB(ENABLE_CMPB)) u_dec (
      .imm_form (imm_form),
      .xop      (xop),
      .imm_op   (imm_op),
      .rec      (rec),
      .ctl      (ctl)
   );

   ilu_alu #(.XLEN(XLEN), .IMM_W(IMM_W), .ENABLE_CMPB(ENABLE_CMPB)) u_alu (
      .ctl (ctl),
      .rs  (rs),
      .rb  (rb),
      .imm (imm),
      .res (alu_res)
   );

   ilu_cond #(.XLEN(XLEN)) u_cond (
      .val (alu_res),
      .so  (so_in),
      .cr  (cr_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res       <= '0;
         cr_out    <= '0;
         cr_we     <= 1'b0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         cr_we     <= in_valid && ctl.legal && ctl.rec_en;
         illegal   <= in_valid && !ctl.legal;
         if (in_valid && ctl.legal) begin
            res <= alu_res;
            if (ctl.rec_en) cr_out <= cr_next;
         end
      end
   end

   // R10
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !cr_we && !illegal && $stable(res) && $stable(cr_out)));
   // R9
   illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (out_valid && !cr_we && $stable(res) && $stable(cr_out)));
   // R5
   cr_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we |-> (cr_out[1] == (res == '0)));
   // R5
   cr_single_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cr_we |-> ($countones(cr_out[3:1]) == 1));
   // R6
   cr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !cr_we) |-> $stable(cr_out));

endmodule

// File: tb/int_logic_unit_tb_top.sv
module int_logic_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        imm_form = 1'b0;
   logic [9:0]  xop = '0;
   logic [2:0]  imm_op = '0;
   logic        rec = 1'b0;
   logic [15:0] imm = '0;
   logic [63:0] rs = '0;
   logic [63:0] rb = '0;
   logic        so_in = 1'b0;
   logic        out_valid;
   logic [63:0] res;
   logic [3:0]  cr_out;
   logic        cr_we;
   logic        illegal;

   int n_cmp = 0;
   int n_bad = 0;

   // model state
   logic [63:0] m_res = '0;
   logic [3:0]  m_cr = '0;
   logic        m_valid = 1'b0;
   logic        m_crwe = 1'b0;
   logic        m_ill = 1'b0;

   always #5 clk = ~clk;

   int_logic_unit dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .imm_form(imm_form),
      .xop(xop), .imm_op(imm_op), .rec(rec), .imm(imm), .rs(rs), .rb(rb),
      .so_in(so_in), .out_valid(out_valid), .res(res), .cr_out(cr_out),
      .cr_we(cr_we), .illegal(illegal)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit legal_x(input logic [9:0] x);
      int codes[12] = '{28, 316, 476, 444, 124, 60, 284, 412, 954, 922, 26, 508};
      foreach (codes[k]) if (int'(x) == codes[k]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [63:0] ref_result(input bit imf, input logic [9:0] x,
      input logic [2:0] io, input logic [15:0] im, input logic [63:0] a, input logic [63:0] b);
      logic [63:0] t;
      int n;
      if (imf) begin
         t = {48'h0, im};
         if (io % 2 == 1) t = t * 64'd65536;
         case (io / 2)
            0: return a | t;
            1: return a ^ t;
            default: return a & t;
         endcase
      end
      case (int'(x))
         28:  return a & b;
         316: return a ^ b;
         476: return ~(a & b);
         444: return a | b;
         124: return ~(a | b);
         60:  return a & ~b;
         284: return ~(a ^ b);
         412: return a | ~b;
         954: return 64'($signed(a[7:0]));
         922: return 64'($signed(a[15:0]));
         26: begin
            n = 0;
            while (n < 32 && a[31-n] == 1'b0) n++;
            return 64'(n);
         end
         508: begin
            t = '0;
            for (int j = 0; j < 8; j++)
               if (a[j*8 +: 8] == b[j*8 +: 8]) t[j*8 +: 8] = 8'hFF;
            return t;
         end
         default: return '0;
      endcase
   endfunction

   function automatic string op_tag(input bit imf, input logic [9:0] x);
      if (imf) return "R7";
      case (int'(x))
         954, 922: return "R2";
         26:       return "R3";
         508:      return "R4";
         default:  return "R1";
      endcase
   endfunction

   task automatic step(input bit v, input bit imf, input logic [9:0] x, input logic [2:0] io,
      input bit r, input logic [15:0] im, input logic [63:0] a, input logic [63:0] b, input bit so);
      bit lg, rc;
      logic [63:0] y;
      string rtag, ctag;
      in_valid = v; imm_form = imf; xop = x; imm_op = io; rec = r; imm = im;
      rs = a; rb = b; so_in = so;
      lg = imf ? (io < 3'd6) : legal_x(x);
      rc = lg && (imf ? (io >= 3'd4) : (r && x != 10'd508));
      y  = ref_result(imf, x, io, im, a, b);
      rtag = v ? op_tag(imf, x) : "R10";
      ctag = !v ? "R10" : imf ? "R8" : (x == 10'd508) ? "R4" : r ? "R5" : "R6";
      if (v && !lg) begin rtag = "R9"; ctag = "R9"; end
      m_valid = v;
      m_ill   = v && !lg;
      m_crwe  = v && rc;
      if (v && lg) begin
         m_res = y;
         if (rc) m_cr = {$signed(y) < 0, $signed(y) > 0, y == 64'd0, so};
      end
      @(posedge clk);
      #1;
      chk("R10 out_valid", 64'(out_valid), 64'(m_valid));
      chk("R9 illegal", 64'(illegal), 64'(m_ill));
      chk({ctag, " cr_we"}, 64'(cr_we), 64'(m_crwe));
      chk({rtag, " res"}, res, m_res);
      chk({ctag, " cr_out"}, 64'(cr_out), 64'(m_cr));
      @(negedge clk);
   endtask

   task automatic reg_op(input int x, input bit r, input logic [63:0] a, input logic [63:0] b, input bit so);
      step(1'b1, 1'b0, 10'(x), 3'd0, r, 16'h0, a, b, so);
   endtask

   task automatic imm_opr(input int io, input bit r, input logic [15:0] im, input logic [63:0] a, input bit so);
      step(1'b1, 1'b1, 10'h3FF, 3'(io), r, im, a, 64'hDEAD_BEEF_0000_FFFF, so);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      int ops[12] = '{28, 316, 476, 444, 124, 60, 284, 412, 954, 922, 26, 508};
      logic [63:0] pa, pb;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 out_valid", 64'(out_valid), 64'd0);
      chk("R11 res", res, 64'd0);
      chk("R11 cr_out", 64'(cr_out), 64'd0);
      chk("R11 cr_we", 64'(cr_we), 64'd0);
      chk("R11 illegal", 64'(illegal), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 logic ops, two patterns each
      pa = 64'hF0F0_1234_FFFF_0000; pb = 64'h0FF0_5678_00FF_FF00;
      for (int k = 0; k < 8; k++) begin
         reg_op(ops[k], 1'b0, pa, pb, 1'b0);
         reg_op(ops[k], 1'b1, pb, pa, 1'b1);
      end
      // R2 sign extension, both signs
      reg_op(954, 1'b0, 64'h1234_5678_9ABC_DE80, 64'h0, 1'b0);
      reg_op(954, 1'b1, 64'hFFFF_FFFF_FFFF_FF7F, 64'h0, 1'b0);
      reg_op(922, 1'b1, 64'h0000_0000_0000_8001, 64'h0, 1'b1);
      reg_op(922, 1'b0, 64'hFFFF_0000_0000_7FFF, 64'h0, 1'b0);
      // R3 leading zeros: zero low word, top bit, low bit, upper half ignored
      reg_op(26, 1'b1, 64'hFFFF_FFFF_0000_0000, 64'h0, 1'b0);
      reg_op(26, 1'b0, 64'h0000_0000_8000_0000, 64'h0, 1'b0);
      reg_op(26, 1'b0, 64'h0000_0000_0000_0001, 64'h0, 1'b0);
      reg_op(26, 1'b1, 64'h0000_0000_0000_0000, 64'h0, 1'b1);
      reg_op(26, 1'b0, 64'h0000_0001_0004_0000, 64'h0, 1'b0);
      // R4 byte compare with rec set: no condition update
      reg_op(28, 1'b1, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
      reg_op(508, 1'b1, 64'h1122_3344_5566_7788, 64'h1100_3344_0066_7788, 1'b1);
      reg_op(508, 1'b0, 64'h0, 64'h0, 1'b0);
      // R5 zero and positive results with SO toggling
      reg_op(28, 1'b1, 64'h00FF, 64'hFF00, 1'b1);
      reg_op(444, 1'b1, 64'h0001, 64'h0000, 1'b0);
      // R6 no record keeps field
      reg_op(476, 1'b0, 64'h0, 64'h0, 1'b1);
      // R7 / R8 immediate forms with garbage xop
      imm_opr(0, 1'b1, 16'h8001, 64'hFFFF_0000_0000_0000, 1'b1);
      imm_opr(1, 1'b1, 16'h8001, 64'h0, 1'b0);
      imm_opr(2, 1'b0, 16'hFFFF, 64'h1234_5678_9ABC_DEF0, 1'b0);
      imm_opr(3, 1'b0, 16'hFFFF, 64'h1234_5678_9ABC_DEF0, 1'b1);
      imm_opr(4, 1'b0, 16'h00F0, 64'hFFFF_FFFF_FFFF_FF0F, 1'b1);
      imm_opr(5, 1'b0, 16'h8000, 64'h0000_0000_8000_0000, 1'b0);
      imm_opr(4, 1'b1, 16'hFFFF, 64'h0000_0000_0000_1234, 1'b1);
      // R9 undefined opcodes straight after a recording op
      reg_op(28, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 1'b1);
      reg_op(27, 1'b1, 64'h1, 64'h2, 1'b0);
      reg_op(0, 1'b0, 64'h3, 64'h4, 1'b0);
      imm_opr(6, 1'b1, 16'h1, 64'h5, 1'b0);
      imm_opr(7, 1'b0, 16'h1, 64'h5, 1'b1);
      // R10 idle cycles with changing inputs
      step(1'b0, 1'b0, 10'd28, 3'd0, 1'b1, 16'h0, 64'h77, 64'h77, 1'b1);
      step(1'b0, 1'b1, 10'd0, 3'd4, 1'b1, 16'hFFFF, 64'h1, 64'h0, 1'b0);
      // mixed back-to-back stream
      for (int n = 0; n < 400; n++) begin
         bit v = ($urandom % 8) != 0;
         bit imf = ($urandom % 4) == 0;
         int sel = $urandom % 14;
         int x = (sel < 12) ? ops[sel] : int'($urandom % 1024);
         logic [63:0] a = {$urandom, $urandom};
         logic [63:0] b = ($urandom % 3 == 0) ? a ^ (64'hFF << (8 * ($urandom % 8))) : {$urandom, $urandom};
         if ($urandom % 5 == 0) a = '0;
         if ($urandom % 6 == 0) b = ~a;
         step(v, imf, 10'(x), 3'($urandom % 8), 1'($urandom), 16'($urandom), a, b, 1'($urandom));
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule